// File: doc/BRIEF.md
# Strobe-Latched Read-Only Memory with Chip Select

This block is a read-only word store with an output holding latch. It has 256 words of 10 bits each, selected by an 8-bit address. Reads are not a direct path from address to data. The address is held in a register, and two read strobes decide when that register may take a new address and when the holding latch takes the addressed word. The contents are fixed at build time by a formula in the shared package.

While the read-window strobe is high, the latch reloads from the array on every clock edge, so the outputs track the addressed word. When that strobe goes low, the latch freezes on the last word it loaded. The address-freeze strobe works on its own: while it is low, the address register ignores the address pins. The two strobes may be complements of each other or fully independent.

A chip-enable input and a 3-bit chip-select compare gate the outputs. The compare checks each bit against a parameter, and each bit can be set to must-be-0, must-be-1 or don't-care. The result is a drive-enable flag; the data pins read as zero while it is low. Gating does not stop the latch, so a word read while the chip is gated off appears when the chip is enabled again. A helper splits the output word into octal digits, one per nibble, for display and checking.

Top module: `strobe_latch_rom`

## Requirements
- R1: An active-low reset clears the address register and the holding latch to zero. Right after reset, with the chip driven, `dataOut` and `octalOut` are both zero.
- R2: On a rising clock edge where `readStrobeN` is 1, the address register loads `addrIn`. Where `readStrobeN` is 0, it keeps its value whatever `addrIn` does.
- R3: On a rising clock edge where `readStrobe` is 1, the latch loads the array word at the current address register value (the value before that same edge). The result is seen on `dataOut` after that edge.
- R4: On a rising clock edge where `readStrobe` is 0, the latch keeps its word, even if the address register changes.
- R5: `driveEn` is 1 only when `chipEn` is 1 and the chip-select compare matches. This is combinational in the same cycle. While `driveEn` is 0, `dataOut` and `octalOut` are all zeros.
- R6: Chip-select bit i is compared with bit i of `SEL_VALUE` only when bit i of `SEL_CARE` is 1; otherwise that bit is ignored. With the defaults (`SEL_CARE`=3'b101, `SEL_VALUE`=3'b100), the patterns 3'b100 and 3'b110 match and all others do not.
- R7: Reads done while `driveEn` is 0 still update the latch. The new word shows on `dataOut` as soon as `driveEn` returns to 1.
- R8: `octalOut` puts octal digit k of `dataOut` in nibble k: bits [4k+2:4k] carry data bits [3k+2:3k], and bit 4k+3 is 0. The top digit holds only data bit 9. For example, data 10'b1010011110 gives 16'h1236.
- R9: Array word at address a equals (a*37 + 670) mod 1024. Address 0 therefore holds 10'b1010011110.
- R10: The two strobes act independently. When both are 1 on the same edge, the address loads and the latch takes the word at the previous address, both at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| addrIn | input | 8 | Word address |
| readStrobe | input | 1 | Read window: 1 reloads the latch each edge, 0 holds it |
| readStrobeN | input | 1 | Address gate: 1 loads the address register, 0 freezes it |
| chipEn | input | 1 | Chip enable, active high |
| chipSel | input | 3 | Chip-select code compared with the programmed pattern |
| dataOut | output | 10 | Latched word, zero while not driven |
| driveEn | output | 1 | Output drive flag (1 = driven, 0 = open) |
| octalOut | output | 16 | Octal digits of `dataOut`, one per nibble |

## Verification
`driveEn` and its gating of `dataOut` and `octalOut` follow `chipEn` and `chipSel` in the same cycle. The address register and the latch each change on one rising edge, so a new address reaches `dataOut` two edges after it is presented. The bench changes inputs on the falling edge and steps its own address and latch model at the next rising edge. It then samples all three outputs at the falling edge after that, so every expected value sits exactly one register stage behind its stimulus.

// File: rtl/srom_pkg.sv
package srom_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic loadAddr;   // address register takes addrIn this edge
    logic loadLatch;  // holding latch takes the array word this edge
    logic drive;      // outputs are driven
  } sromCtrlT;

  // Array contents as an unbounded integer; the caller truncates to the word width.
  function automatic int unsigned romSeed(int unsigned addr);
    return addr * 37 + 670;
  endfunction

endpackage

// File: rtl/srom_ctrl.sv
module srom_ctrl
  import srom_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter logic [SEL_W-1:0] SEL_CARE  = 3'b101,
  parameter logic [SEL_W-1:0] SEL_VALUE = 3'b100
) (
  input  logic             readStrobe,
  input  logic             readStrobeN,
  input  logic             chipEn,
  input  logic [SEL_W-1:0] chipSel,
  output sromCtrlT         ctrl
);

  logic [SEL_W-1:0] bitOk;

  // One comparator per select bit; a don't-care bit always passes.
  for (genvar i = 0; i < SEL_W; i++) begin : g_sel
    if (SEL_CARE[i]) begin : g_care
      assign bitOk[i] = (chipSel[i] == SEL_VALUE[i]);
    end else begin : g_free
      assign bitOk[i] = 1'b1;
    end
  end

  always_comb begin
    ctrl.loadAddr  = readStrobeN;
    ctrl.loadLatch = readStrobe;
    ctrl.drive     = chipEn & (&bitOk);
  end

endmodule

// File: rtl/srom_datapath.sv
module srom_datapath
  import srom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  sromCtrlT          ctrl,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [DATA_W-1:0] dataOut
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] romTable [DEPTH];
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] latchReg;
  logic [DATA_W-1:0] arrayWord;

  // Fixed contents computed per entry at elaboration.
  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign romTable[g] = DATA_W'(romSeed(g));
  end

  assign arrayWord = romTable[addrReg];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (ctrl.loadAddr) begin
      addrReg <= addrIn;
    end
  end

  // Loading continues while the outputs are gated off.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchReg <= '0;
    end else if (ctrl.loadLatch) begin
      latchReg <= arrayWord;
    end
  end

  assign dataOut = ctrl.drive ? latchReg : '0;

endmodule

// File: rtl/srom_octal.sv
module srom_octal #(
  parameter int DATA_W = 10,
  localparam int DIGITS = (DATA_W + 2) / 3
) (
  input  logic [DATA_W-1:0]   word,
  output logic [4*DIGITS-1:0] octalOut
);

  localparam int PAD_W = 3 * DIGITS;

  logic [PAD_W-1:0] padded;

  assign padded = PAD_W'(word);

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    assign octalOut[4*i +: 4] = {1'b0, padded[3*i +: 3]};
  end

endmodule

// File: rtl/strobe_latch_rom.sv
module strobe_latch_rom
  import srom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 10,
  parameter int SEL_W  = 3,
  parameter logic [SEL_W-1:0] SEL_CARE  = 3'b101,
  parameter logic [SEL_W-1:0] SEL_VALUE = 3'b100,
  localparam int DIGITS = (DATA_W + 2) / 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic                readStrobe,
  input  logic                readStrobeN,
  input  logic                chipEn,
  input  logic [SEL_W-1:0]    chipSel,
  output logic [DATA_W-1:0]   dataOut,
  output logic                driveEn,
  output logic [4*DIGITS-1:0] octalOut
);

  sromCtrlT ctrl;

  srom_ctrl #(
    .SEL_W    (SEL_W),
    .SEL_CARE (SEL_CARE),
    .SEL_VALUE(SEL_VALUE)
  ) u_ctrl (
    .readStrobe (readStrobe),
    .readStrobeN(readStrobeN),
    .chipEn     (chipEn),
    .chipSel    (chipSel),
    .ctrl       (ctrl)
  );

  srom_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .addrIn (addrIn),
    .dataOut(dataOut)
  );

  srom_octal #(
    .DATA_W(DATA_W)
  ) u_oct (
    .word    (dataOut),
    .octalOut(octalOut)
  );

  assign driveEn = ctrl.drive;

endmodule

// File: rtl/srom_checker.sv
module srom_checker (
  input logic        clk,
  input logic        rstN,
  input logic [7:0]  addrIn,
  input logic        readStrobe,
  input logic        readStrobeN,
  input logic        chipEn,
  input logic [2:0]  chipSel,
  input logic [9:0]  dataOut,
  input logic        driveEn,
  input logic [15:0] octalOut
);

  // R5
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !chipEn |-> (!driveEn && dataOut == '0 && octalOut == '0));

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(readStrobe) && driveEn && $past(driveEn)) |-> $stable(dataOut));

  // R2
  frozen_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(rstN, 2) && $past(readStrobe) && !$past(readStrobeN)
     && $past(readStrobe, 2) && !$past(readStrobeN, 2) && driveEn && $past(driveEn))
    |-> $stable(dataOut));

  // R8
  octal_split_chk: assert property (@(posedge clk) disable iff (!rstN)
    driveEn |-> ({octalOut[12], octalOut[10:8], octalOut[6:4], octalOut[2:0]} == dataOut
                 && octalOut[15:13] == 3'b000));

  // R5
  gated_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !driveEn |-> (dataOut == '0));

endmodule

bind strobe_latch_rom srom_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .addrIn     (addrIn),
  .readStrobe (readStrobe),
  .readStrobeN(readStrobeN),
  .chipEn     (chipEn),
  .chipSel    (chipSel),
  .dataOut    (dataOut),
  .driveEn    (driveEn),
  .octalOut   (octalOut)
);

// File: tb/tb_strobe_latch_rom.sv
`timescale 1ns/1ps
module tb_strobe_latch_rom;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  addrIn = '0;
  logic        readStrobe = 1'b0;
  logic        readStrobeN = 1'b0;
  logic        chipEn = 1'b1;
  logic [2:0]  chipSel = 3'b100;
  logic [9:0]  dataOut;
  logic        driveEn;
  logic [15:0] octalOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Bench model state, stepped from the requirements.
  logic [7:0] mAddr = '0;
  logic [9:0] mLatch = '0;

  always #4 clk = ~clk;

  strobe_latch_rom dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .readStrobe(readStrobe),
    .readStrobeN(readStrobeN), .chipEn(chipEn), .chipSel(chipSel),
    .dataOut(dataOut), .driveEn(driveEn), .octalOut(octalOut)
  );

  // R9 contents
  function automatic logic [9:0] bRom(logic [7:0] a);
    int unsigned v;
    v = (int'(a) * 37 + 670) % 1024;
    return v[9:0];
  endfunction

  // R8 digit layout
  function automatic logic [15:0] bOct(logic [9:0] w);
    return {3'b000, w[9], 1'b0, w[8:6], 1'b0, w[5:3], 1'b0, w[2:0]};
  endfunction

  // R6 with SEL_CARE=101, SEL_VALUE=100
  function automatic logic bDrive(logic ce, logic [2:0] sel);
    return ce && sel[2] && !sel[0];
  endfunction

  task automatic checkOut(string tag);
    logic       eDrive;
    logic [9:0] eData;
    eDrive = bDrive(chipEn, chipSel);
    eData  = eDrive ? mLatch : 10'd0;
    checks++;
    if (driveEn !== eDrive) begin
      failures++;
      $display("FAIL %s driveEn actual=%0b expected=%0b", tag, driveEn, eDrive);
    end
    checks++;
    if (dataOut !== eData) begin
      failures++;
      $display("FAIL %s dataOut actual=%h expected=%h", tag, dataOut, eData);
    end
    checks++;
    if (octalOut !== bOct(eData)) begin
      failures++;
      $display("FAIL %s octalOut actual=%h expected=%h", tag, octalOut, bOct(eData));
    end
  endtask

  // Drive at the falling edge, step the model at the rising edge, check at the next falling edge.
  task automatic step(logic [7:0] a, logic rd, logic rdN, logic ce, logic [2:0] sel, string tag);
    addrIn = a; readStrobe = rd; readStrobeN = rdN; chipEn = ce; chipSel = sel;
    @(posedge clk);
    if (rd)  mLatch = bRom(mAddr);
    if (rdN) mAddr = a;
    @(negedge clk);
    checkOut(tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 reset state");

    // R9 / R3: load address 5, then read it through the window.
    step(8'd5, 1'b0, 1'b1, 1'b1, 3'b100, "R2 load address");
    step(8'd5, 1'b1, 1'b0, 1'b1, 3'b100, "R3 follow addressed word");
    checks++;
    if (dataOut !== bRom(8'd5)) begin
      failures++;
      $display("FAIL R9 word at 5 actual=%h expected=%h", dataOut, bRom(8'd5));
    end

    // R4: window closed, address changes, latch holds.
    step(8'd77, 1'b0, 1'b1, 1'b1, 3'b100, "R4 hold across address change");
    step(8'd200, 1'b0, 1'b1, 1'b1, 3'b100, "R4 hold across address change");

    // R2: freeze at 200, wiggle the pins while reading.
    step(8'd13, 1'b1, 1'b0, 1'b1, 3'b100, "R2 frozen address read");
    step(8'd99, 1'b1, 1'b0, 1'b1, 3'b100, "R2 frozen address read");
    checks++;
    if (dataOut !== bRom(8'd200)) begin
      failures++;
      $display("FAIL R2 frozen word actual=%h expected=%h", dataOut, bRom(8'd200));
    end

    // R7: read a new address while gated off, then re-enable.
    step(8'd42, 1'b0, 1'b1, 1'b0, 3'b100, "R5 gated off");
    step(8'd42, 1'b1, 1'b0, 1'b0, 3'b100, "R7 read while disabled");
    step(8'd42, 1'b0, 1'b1, 1'b0, 3'b100, "R7 read while disabled");
    step(8'd42, 1'b0, 1'b1, 1'b1, 3'b100, "R7 shown on re-enable");
    checks++;
    if (dataOut !== bRom(8'd42)) begin
      failures++;
      $display("FAIL R7 word after re-enable actual=%h expected=%h", dataOut, bRom(8'd42));
    end

    // R6: every select pattern.
    for (int s = 0; s < 8; s++) begin
      step(8'd42, 1'b0, 1'b1, 1'b1, 3'(s), "R6 select compare");
    end

    // R10: both strobes high on the same edges.
    step(8'd7, 1'b1, 1'b1, 1'b1, 3'b110, "R10 both strobes high");
    step(8'd8, 1'b1, 1'b1, 1'b1, 3'b110, "R10 both strobes high");
    step(8'd8, 1'b0, 1'b0, 1'b1, 3'b110, "R10 both strobes high");

    // R8 with address 0.
    step(8'd0, 1'b0, 1'b1, 1'b1, 3'b100, "R8 setup");
    step(8'd0, 1'b1, 1'b0, 1'b1, 3'b100, "R8 read address 0");
    checks++;
    if (octalOut !== 16'h1236) begin
      failures++;
      $display("FAIL R8 octal of word 0 actual=%h expected=1236", octalOut);
    end

    // Random phase with a mix of strobe, enable and select patterns.
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      logic rd, rdN, ce;
      logic [2:0] sel;
      a   = 8'($urandom);
      rd  = 1'($urandom);
      rdN = ($urandom % 4 == 0) ? rd : ~rd;
      ce  = ($urandom % 5) != 0;
      sel = ($urandom % 3 == 0) ? 3'($urandom) : 3'b100;
      if (!bDrive(ce, sel))      step(a, rd, rdN, ce, sel, "R5 random gated");
      else if (rd)               step(a, rd, rdN, ce, sel, "R3 random read");
      else                       step(a, rd, rdN, ce, sel, "R4 random hold");
    end

    summary();
  end

endmodule